// File: doc/BRIEF.md
# Audio Sample Clock Generator

This block produces the bit clock and the frame (word) clock of a digital audio serial port when the port owns the clocks. It also produces an enable pulse train that paces the oversampling modulator. A phase accumulator runs on the prescaled clock. On every cycle it adds a 15-bit coefficient, so any sample rate from 8 kHz to 96 kHz can be reached from a single prescaled clock. This covers both the 44.1 kHz family (11.025, 22.05, 88.2 kHz) and the 48 kHz family. The sample rate is f_clk × coefficient / 2^22. Each wrap of the 22-bit accumulator starts a new frame. Its top seven bits give the half-bit position inside the frame. This yields 64 bit-clock periods per frame, 32 for each channel.

A small sequencer with three states controls the outputs: `GEN_IDLE`, `GEN_ARM` and `GEN_RUN`. The transitions are IDLE→ARM when the rate field enables the clock, ARM→RUN when it is still enabled, ARM→IDLE when it is not, and RUN→IDLE when the rate field disables the clock. In ARM the accumulator clears and picks up the coefficient. In RUN the accumulator advances. The bit-clock polarity setting chooses whether frame-clock transitions fall on a falling or a rising bit-clock edge. A coefficient written while running is held back until the next frame boundary.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is asserted, and after it is released with the rate field at 11, `bclk`, `wclk` and `mod_en` are all 0.
- R2: The coefficient is `{coef_hi[6:0], coef_lo[7:0]}`, with `coef_hi` supplying bits 14:8.
- R3: In the running state a 22-bit accumulator, cleared on entry, adds the coefficient once per clock. The m-th frame boundary (a falling edge of `wclk`) comes ceil(m·2^22/coef) cycles after the accumulator starts. The spacing between boundaries follows that formula, also for coefficients that are not powers of two.
- R4: Between two frame boundaries `bclk` has exactly 64 rising edges. `wclk` is low for the first 32 bit periods and high for the last 32.
- R5: With `bclk_inv`=0, every change of `wclk` coincides with a falling edge of `bclk`. With `bclk_inv`=1, every change coincides with a rising edge.
- R6: Rate field 10 (high performance) drives `mod_en` to 1 on every cycle, starting one cycle after the field is applied.
- R7: Rate field 00 (low power) toggles `mod_en` every cycle, so it is high on half of the cycles.
- R8: Rate field 11 holds `mod_en`, `bclk` and `wclk` at 0 from the cycle after it is applied. A later enable restarts the accumulator from zero.
- R9: The reserved rate field 01 behaves exactly as 11.
- R10: A coefficient changed during a frame does not alter that frame's length. The new value applies from the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_hi | input | 7 | Coefficient bits 14:8 |
| coef_lo | input | 8 | Coefficient bits 7:0 |
| rate_sel | input | 2 | 00 low power, 01 reserved (off), 10 high performance, 11 off |
| bclk_inv | input | 1 | Bit-clock polarity select |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Frame (word) clock |
| mod_en | output | 1 | Modulator clock enable |

## Verification
`mod_en` responds one clock edge after a new rate field. The clocks start two edges after an enable (IDLE→ARM→RUN) and return to 0 one edge after a disable. The bench therefore waits several cycles after each rate change before counting `mod_en` or clock activity. Frame boundaries follow the ceiling formula counted from accumulator start. The monitor samples on the falling clock edge and compares only the cycle distance between successive `wclk` falls, so the fixed start-up latency does not enter any expected value. Each expected interval is queued by the driver before the frame that produces it begins.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'b00,
        RATE_RSV  = 2'b01,
        RATE_HIGH = 2'b10,
        RATE_OFF  = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'b00,
        GEN_ARM  = 2'b01,
        GEN_RUN  = 2'b10
    } gen_state_e;

    function automatic logic rate_active(input logic [1:0] r);
        return (r == RATE_LOW) || (r == RATE_HIGH);
    endfunction

endpackage

// File: rtl/acg_seq.sv
module acg_seq
    import audio_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    output gen_state_e state,
    output logic       clr,
    output logic       run
);

    gen_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GEN_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            GEN_IDLE: if (enable)  nxt = GEN_ARM;
            GEN_ARM:  nxt = enable ? GEN_RUN : GEN_IDLE;
            GEN_RUN:  if (!enable) nxt = GEN_IDLE;
            default:  nxt = GEN_IDLE;
        endcase
    end

    always_comb begin
        clr = 1'b0;
        run = 1'b0;
        unique case (state)
            GEN_ARM:  clr = 1'b1;
            GEN_RUN:  run = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/acg_phase.sv
module acg_phase #(
    parameter int COEF_W = 15,
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic [COEF_W-1:0] coef_in,
    output logic [SLOT_W-1:0] slot,
    output logic              wrap
);

    localparam int ACC_W = COEF_W + SLOT_W;

    logic [ACC_W-1:0]  acc;
    logic [COEF_W-1:0] coef_act;
    logic [ACC_W:0]    sum;

    assign sum  = {1'b0, acc} + {{(SLOT_W + 1){1'b0}}, coef_act};
    assign wrap = run & sum[ACC_W];
    assign slot = acc[ACC_W-1 -: SLOT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            coef_act <= '0;
        end else if (clr) begin
            acc      <= '0;
            coef_act <= coef_in;
        end else if (run) begin
            acc <= sum[ACC_W-1:0];
            if (sum[ACC_W]) coef_act <= coef_in;
        end
    end

endmodule

// File: rtl/acg_modgate.sv
module acg_modgate
    import audio_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       mod_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_en <= 1'b0;
        end else begin
            unique case (rate_e'(rate_sel))
                RATE_HIGH: mod_en <= 1'b1;
                RATE_LOW:  mod_en <= ~mod_en;
                default:   mod_en <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int COEF_W   = 15,
    parameter int LO_W     = 8,
    parameter int BCLK_PER = 64,
    localparam int HI_W    = COEF_W - LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HI_W-1:0] coef_hi,
    input  logic [LO_W-1:0] coef_lo,
    input  logic [1:0]      rate_sel,
    input  logic            bclk_inv,
    output logic            bclk,
    output logic            wclk,
    output logic            mod_en
);

    localparam int SLOT_W = $clog2(2 * BCLK_PER);

    gen_state_e        gen_state;
    logic              gen_clr;
    logic              gen_run;
    logic [SLOT_W-1:0] slot;
    logic              frame_wrap;
    logic [COEF_W-1:0] coef_word;

    assign coef_word = {coef_hi, coef_lo};

    acg_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rate_active(rate_sel)),
        .state  (gen_state),
        .clr    (gen_clr),
        .run    (gen_run)
    );

    acg_phase #(
        .COEF_W (COEF_W),
        .SLOT_W (SLOT_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (gen_clr),
        .run     (gen_run),
        .coef_in (coef_word),
        .slot    (slot),
        .wrap    (frame_wrap)
    );

    acg_modgate u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .mod_en   (mod_en)
    );

    // Even slots hold bclk low (inverted: high); both wclk edges land on even slots.
    always_comb begin
        bclk = 1'b0;
        wclk = 1'b0;
        if (gen_run) begin
            bclk = slot[0] ^ bclk_inv;
            wclk = slot[SLOT_W-1];
        end
    end

endmodule

// File: rtl/acg_chk.sv
module acg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rate_sel,
    input logic       bclk_inv,
    input logic       bclk,
    input logic       wclk,
    input logic       mod_en,
    input logic       running
);

    // R5
    edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && (wclk != $past(wclk)) && $stable(bclk_inv))
        |-> (bclk == bclk_inv && $past(bclk) != bclk_inv));

    // R6
    mod_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b10) |=> mod_en);

    // R7
    mod_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b00) |=> (mod_en != $past(mod_en)));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b11) |=> (!bclk && !wclk && !mod_en));

    // R9
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b01) |=> (!bclk && !wclk && !mod_en));

endmodule

bind audio_clkgen acg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .bclk_inv (bclk_inv),
    .bclk     (bclk),
    .wclk     (wclk),
    .mod_en   (mod_en),
    .running  (gen_run)
);

// File: tb/sim_audio_clkgen.sv
`timescale 1ns/1ps
module sim_audio_clkgen;

    localparam longint FULL = 64'd1 << 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] coef_hi = '0;
    logic [7:0] coef_lo = '0;
    logic [1:0] rate_sel = 2'b11;
    logic       bclk_inv = 1'b0;
    logic       bclk, wclk, mod_en;

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    int     exp_q[$];
    bit     armed    = 1'b0;
    bit     have_last = 1'b0;
    longint last_fall = 0;
    int     rises = 0;
    logic   p_bclk = 1'b0, p_wclk = 1'b0;

    always #2.5 clk = ~clk;

    audio_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .coef_hi(coef_hi), .coef_lo(coef_lo),
        .rate_sel(rate_sel), .bclk_inv(bclk_inv),
        .bclk(bclk), .wclk(wclk), .mod_en(mod_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected frame lengths as wclk falls arrive
    always @(negedge clk) begin
        if (rst_n && armed) begin
            if (bclk && !p_bclk) rises++;
            if (wclk != p_wclk) begin
                // R5: the edge type depends on bclk_inv
                chk(bclk == bclk_inv && p_bclk != bclk_inv, "R5 edge", longint'(bclk), longint'(bclk_inv));
            end
            if (!wclk && p_wclk) begin
                if (have_last && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    // R3 / R10 frame interval, R4 bit clocks per frame
                    chk(cyc - last_fall == e, "R3/R10 frame length", cyc - last_fall, e);
                    chk(rises == 64, "R4 bclk per frame", rises, 64);
                end
                have_last = 1'b1;
                last_fall = cyc;
                rises = 0;
            end
        end
        p_bclk = bclk;
        p_wclk = wclk;
    end

    function automatic int bound(input longint m, input longint c);
        return int'(((m * FULL) + c - 1) / c);
    endfunction

    task automatic set_coef(input int c);
        coef_hi = c[14:8];
        coef_lo = c[7:0];
    endtask

    task automatic wait_empty();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // driver: restart the generator and queue the expected intervals
    task automatic run_frames(input int c, input bit inv, input int n);
        armed = 1'b0;
        @(negedge clk);
        rate_sel = 2'b11;
        repeat (4) @(negedge clk);
        have_last = 1'b0;
        rises = 0;
        bclk_inv = inv;
        set_coef(c);
        for (int m = 1; m <= n; m++)
            exp_q.push_back(bound(m + 1, c) - bound(m, c));
        rate_sel = 2'b10;
        armed = 1'b1;
        wait_empty();
    endtask

    task automatic check_rate(input logic [1:0] r, input int exp_ones, input string req);
        int ones, act;
        armed = 1'b0;
        @(negedge clk);
        rate_sel = r;
        repeat (3) @(negedge clk);
        ones = 0;
        act = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            ones += int'(mod_en);
            act += int'(bclk) + int'(wclk);
        end
        chk(ones == exp_ones, {req, " mod_en count"}, ones, exp_ones);
        if (r[0]) chk(act == 0, {req, " clocks held low"}, act, 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!bclk && !wclk && !mod_en, "R1 in reset", {bclk, wclk, mod_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 after release with rate off
        chk(!bclk && !wclk && !mod_en, "R1 after reset", {bclk, wclk, mod_en}, 0);

        // R3 power-of-two coefficients
        run_frames(32'h4000, 1'b0, 3);
        run_frames(32'h2000, 1'b0, 2);
        // R2 split fields, R3 fractional spacing
        run_frames(32'h2AB5, 1'b0, 5);
        run_frames(32'h6000, 1'b0, 4);
        // R5 inverted polarity
        run_frames(32'h4000, 1'b1, 2);

        // R10: change coefficient mid-frame
        run_frames(32'h4000, 1'b0, 1);
        repeat (10) @(negedge clk);
        set_coef(32'h2000);
        exp_q.push_back(256);
        exp_q.push_back(512);
        wait_empty();

        // R6 R7 R8 R9
        check_rate(2'b10, 100, "R6");
        check_rate(2'b00, 50,  "R7");
        check_rate(2'b11, 0,   "R8");
        check_rate(2'b01, 0,   "R9");

        // R8: re-enable restarts from zero
        run_frames(32'h2AB5, 1'b0, 2);

        armed = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule